// File: doc/BRIEF.md
# Reset Cause and Break Wake Status Unit

This unit records why the device last came out of reset and whether a break interrupt ended a wait or stop period. Each reset source delivers a one-cycle event pulse; the unit keeps a sticky flag for each source. A power-on event is special: it sets its own flag and wipes every other one. Software reads the reset cause register to learn the source. The read returns the current flags and clears them all at the end of that bus cycle, so the next reset leaves only its own flag behind.

A second register holds one flag. The flag is set when a break interrupt pulse arrives while the core signals that it is in a low-power mode. Software clears it by writing a zero to that bit. Any reset event also clears it. Both registers sit on a simple peripheral bus with a select, an address, read and write strobes, and a combinational read data path. The break register is at offset 0 and the reset cause register is at offset 1.

Top module: `rstcause_ctl`

## Requirements
- R1: After the reset input is released, offset 1 reads 0x80 and offset 0 reads 0x00.
- R2: The reset cause byte holds these flags: bit 7 power-on, bit 6 external pin, bit 5 watchdog, bit 4 illegal opcode, bit 3 illegal address, bit 1 low-voltage. Bits 2 and 0 always read 0. A non-power-on event sets its own flag and leaves the flags already set unchanged.
- R3: A power-on event sets bit 7 and clears every other flag, even when other events arrive in the same cycle.
- R4: A read of offset 1 returns the flags as they stand in that cycle and clears all of them at the following clock edge.
- R5: A reset event that arrives in the same cycle as a clearing read keeps its flag set afterwards.
- R6: A write to offset 1 leaves the reset cause flags unchanged.
- R7: A break pulse while the low-power input is high sets bit 1 of offset 0. All other bits of offset 0 read 0.
- R8: A break pulse while the low-power input is low leaves the break flag unchanged.
- R9: A write to offset 0 with data bit 1 equal to 0 clears the break flag. A write with data bit 1 equal to 1 has no effect. A set and a clearing write in the same cycle leave the flag set.
- R10: Any reset event clears the break flag, and this takes priority over a set in the same cycle.
- R11: A read of offset 0 does not clear the break flag. The read data is 0x00 in any cycle without both select and read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| evt_por | input | 1 | Power-on reset event pulse |
| evt_pin | input | 1 | External pin reset event pulse |
| evt_wdog | input | 1 | Watchdog timeout reset event pulse |
| evt_ilop | input | 1 | Illegal opcode reset event pulse |
| evt_iladr | input | 1 | Illegal address reset event pulse |
| evt_lvd | input | 1 | Low-voltage reset event pulse |
| brk_pulse | input | 1 | Break interrupt pulse |
| core_lowpwr | input | 1 | Core is in wait or stop mode |
| bus_sel | input | 1 | Bus select for this unit |
| bus_addr | input | ADDR_W | Register offset |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational |

## Verification
The hardest situations are the collisions. An event can land in the same cycle as a clearing read. A power-on event can coincide with other sources. A break set can meet a clearing write or a reset event. Random traffic with sparse events reaches these only now and then, so directed cycles drive each collision on purpose. A reference model in the bench, fed with the same random stream, then checks every read over several thousand cycles.

// File: rtl/rstcause_pkg.sv
package rstcause_pkg;

  localparam int REG_W = 8;

  // Bit positions within the reset cause byte
  localparam int POS_POR   = 7;
  localparam int POS_PIN   = 6;
  localparam int POS_WDOG  = 5;
  localparam int POS_ILOP  = 4;
  localparam int POS_ILADR = 3;
  localparam int POS_LVD   = 1;

  // Bit position of the break wake flag
  localparam int POS_BRK = 1;

  // Register offsets
  localparam int OFS_BRK = 0;
  localparam int OFS_RST = 1;

  typedef struct packed {
    logic por;
    logic pin;
    logic wdog;
    logic ilop;
    logic iladr;
    logic lvd;
  } rst_evt_t;

  function automatic logic [REG_W-1:0] evt_to_byte(input rst_evt_t e);
    logic [REG_W-1:0] b;
    b            = '0;
    b[POS_POR]   = e.por;
    b[POS_PIN]   = e.pin;
    b[POS_WDOG]  = e.wdog;
    b[POS_ILOP]  = e.ilop;
    b[POS_ILADR] = e.iladr;
    b[POS_LVD]   = e.lvd;
    return b;
  endfunction

  function automatic rst_evt_t byte_to_evt(input logic [REG_W-1:0] b);
    rst_evt_t e;
    e.por   = b[POS_POR];
    e.pin   = b[POS_PIN];
    e.wdog  = b[POS_WDOG];
    e.ilop  = b[POS_ILOP];
    e.iladr = b[POS_ILADR];
    e.lvd   = b[POS_LVD];
    return e;
  endfunction

endpackage

// File: rtl/rstcause_rstsync.sv
module rstcause_rstsync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  generate
    if (STAGES == 1) begin : g_one
      always_comb sync_d = 1'b1;
    end else begin : g_many
      always_comb sync_d = {sync_q[STAGES-2:0], 1'b1};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/rstcause_flags.sv
module rstcause_flags
  import rstcause_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  rst_evt_t         evt,
  input  logic             rd_clr,
  output logic [REG_W-1:0] rst_byte
);

  rst_evt_t flags_q;
  rst_evt_t flags_d;
  logic     flags_en;

  // Next state: the clearing read first, then the events on top.
  // A power-on event replaces everything with its own flag.
  always_comb begin
    flags_d = rd_clr ? rst_evt_t'('0) : flags_q;
    if (evt.por) begin
      flags_d     = '0;
      flags_d.por = 1'b1;
    end else begin
      flags_d = flags_d | evt;
    end
    flags_en = rd_clr | (|evt);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags_q     <= '0;
      flags_q.por <= 1'b1;
    end else if (flags_en) begin
      flags_q <= flags_d;
    end
  end

  assign rst_byte = evt_to_byte(flags_q);

endmodule

// File: rtl/rstcause_brk.sv
module rstcause_brk (
  input  logic clk,
  input  logic rst_n,
  input  logic any_rst_evt,
  input  logic brk_pulse,
  input  logic core_lowpwr,
  input  logic wr_clr,
  output logic brk_flag
);

  logic brk_q;
  logic brk_d;
  logic brk_en;
  logic set_req;

  always_comb begin
    set_req = brk_pulse & core_lowpwr;
    brk_en  = any_rst_evt | set_req | wr_clr;
    if (any_rst_evt) begin
      brk_d = 1'b0;
    end else if (set_req) begin
      brk_d = 1'b1;
    end else begin
      brk_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      brk_q <= 1'b0;
    end else if (brk_en) begin
      brk_q <= brk_d;
    end
  end

  assign brk_flag = brk_q;

endmodule

// File: rtl/rstcause_busif.sv
module rstcause_busif
  import rstcause_pkg::*;
#(
  parameter int ADDR_W = 1
) (
  input  logic              bus_sel,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [REG_W-1:0]  bus_wdata,
  input  logic [REG_W-1:0]  rst_byte,
  input  logic              brk_flag,
  output logic              rd_rst,
  output logic              brk_wr_clr,
  output logic [REG_W-1:0]  bus_rdata
);

  localparam logic [ADDR_W-1:0] A_BRK = ADDR_W'(OFS_BRK);
  localparam logic [ADDR_W-1:0] A_RST = ADDR_W'(OFS_RST);

  logic             hit_brk;
  logic             hit_rst;
  logic [REG_W-1:0] brk_byte;
  logic             unused_wdata;

  always_comb begin
    hit_brk           = bus_sel && (bus_addr == A_BRK);
    hit_rst           = bus_sel && (bus_addr == A_RST);
    rd_rst            = hit_rst && bus_rd;
    brk_wr_clr        = hit_brk && bus_wr && !bus_wdata[POS_BRK];
    brk_byte          = '0;
    brk_byte[POS_BRK] = brk_flag;
    if (bus_rd && hit_rst) begin
      bus_rdata = rst_byte;
    end else if (bus_rd && hit_brk) begin
      bus_rdata = brk_byte;
    end else begin
      bus_rdata = '0;
    end
  end

  assign unused_wdata = ^bus_wdata;

endmodule

// File: rtl/rstcause_ctl.sv
module rstcause_ctl
  import rstcause_pkg::*;
#(
  parameter int ADDR_W      = 1,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              evt_por,
  input  logic              evt_pin,
  input  logic              evt_wdog,
  input  logic              evt_ilop,
  input  logic              evt_iladr,
  input  logic              evt_lvd,
  input  logic              brk_pulse,
  input  logic              core_lowpwr,
  input  logic              bus_sel,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [REG_W-1:0]  bus_wdata,
  output logic [REG_W-1:0]  bus_rdata
);

  logic             rst_sync_n;
  rst_evt_t         evt;
  logic             any_evt;
  logic             rd_rst;
  logic             brk_wr_clr;
  logic [REG_W-1:0] rst_byte;
  logic             brk_flag;

  always_comb begin
    evt.por   = evt_por;
    evt.pin   = evt_pin;
    evt.wdog  = evt_wdog;
    evt.ilop  = evt_ilop;
    evt.iladr = evt_iladr;
    evt.lvd   = evt_lvd;
    any_evt   = |evt;
  end

  rstcause_rstsync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  rstcause_flags u_flags (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .evt      (evt),
    .rd_clr   (rd_rst),
    .rst_byte (rst_byte)
  );

  rstcause_brk u_brk (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .any_rst_evt (any_evt),
    .brk_pulse   (brk_pulse),
    .core_lowpwr (core_lowpwr),
    .wr_clr      (brk_wr_clr),
    .brk_flag    (brk_flag)
  );

  rstcause_busif #(.ADDR_W(ADDR_W)) u_bus (
    .bus_sel    (bus_sel),
    .bus_addr   (bus_addr),
    .bus_rd     (bus_rd),
    .bus_wr     (bus_wr),
    .bus_wdata  (bus_wdata),
    .rst_byte   (rst_byte),
    .brk_flag   (brk_flag),
    .rd_rst     (rd_rst),
    .brk_wr_clr (brk_wr_clr),
    .bus_rdata  (bus_rdata)
  );

endmodule

// File: rtl/rstcause_chk.sv
module rstcause_chk
  import rstcause_pkg::*;
#(
  parameter int ADDR_W = 1
) (
  input logic              clk,
  input logic              rst_sync_n,
  input logic              evt_por,
  input logic              evt_pin,
  input logic              evt_wdog,
  input logic              evt_ilop,
  input logic              evt_iladr,
  input logic              evt_lvd,
  input logic              brk_pulse,
  input logic              core_lowpwr,
  input logic              bus_sel,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_rd,
  input logic              bus_wr,
  input logic [REG_W-1:0]  bus_wdata,
  input logic [REG_W-1:0]  bus_rdata,
  input logic [REG_W-1:0]  rst_byte,
  input logic              brk_flag
);

  logic ev_any;
  logic rd_r;
  logic wr_r;
  logic wr_b;
  logic wz_b;

  always_comb begin
    ev_any = evt_por | evt_pin | evt_wdog | evt_ilop | evt_iladr | evt_lvd;
    rd_r   = bus_sel && bus_rd && (bus_addr == ADDR_W'(OFS_RST));
    wr_r   = bus_sel && bus_wr && (bus_addr == ADDR_W'(OFS_RST));
    wr_b   = bus_sel && bus_wr && (bus_addr == ADDR_W'(OFS_BRK));
    wz_b   = wr_b && !bus_wdata[POS_BRK];
  end

  // R3
  por_only_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    evt_por |=> rst_byte == 8'h80);

  // R4
  rd_clear_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (rd_r && !ev_any) |=> rst_byte == 8'h00);

  // R2
  sticky_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!evt_por && !rd_r) |=> ((rst_byte & $past(rst_byte)) == $past(rst_byte)));

  // R5
  rd_evt_keep_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (rd_r && evt_wdog && !evt_por) |=> rst_byte[POS_WDOG]);

  // R6
  wr_ignore_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (wr_r && !rd_r && !ev_any) |=> $stable(rst_byte));

  // R7
  brk_set_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (brk_pulse && core_lowpwr && !ev_any) |=> brk_flag);

  // R8
  brk_idle_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (brk_pulse && !core_lowpwr && !ev_any && !wz_b) |=> $stable(brk_flag));

  // R9
  brk_wclr_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (wz_b && !(brk_pulse && core_lowpwr)) |=> !brk_flag);

  // R10
  brk_evt_clr_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ev_any |=> !brk_flag);

  // R11
  rdata_idle_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !(bus_sel && bus_rd) |-> bus_rdata == 8'h00);

endmodule

bind rstcause_ctl rstcause_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk         (clk),
  .rst_sync_n  (rst_sync_n),
  .evt_por     (evt_por),
  .evt_pin     (evt_pin),
  .evt_wdog    (evt_wdog),
  .evt_ilop    (evt_ilop),
  .evt_iladr   (evt_iladr),
  .evt_lvd     (evt_lvd),
  .brk_pulse   (brk_pulse),
  .core_lowpwr (core_lowpwr),
  .bus_sel     (bus_sel),
  .bus_addr    (bus_addr),
  .bus_rd      (bus_rd),
  .bus_wr      (bus_wr),
  .bus_wdata   (bus_wdata),
  .bus_rdata   (bus_rdata),
  .rst_byte    (rst_byte),
  .brk_flag    (brk_flag)
);

// File: tb/rstcause_ctl_bench.sv
module rstcause_ctl_bench;

  logic       clk;
  logic       rst_n;
  logic       evt_por, evt_pin, evt_wdog, evt_ilop, evt_iladr, evt_lvd;
  logic       brk_pulse, core_lowpwr;
  logic       bus_sel, bus_rd, bus_wr;
  logic [0:0] bus_addr;
  logic [7:0] bus_wdata;
  logic [7:0] bus_rdata;

  int checks;
  int failures;
  bit done;

  logic [7:0] m_rst;
  logic       m_brk;

  rstcause_ctl u_rstcause_ctl (
    .clk(clk), .rst_n(rst_n),
    .evt_por(evt_por), .evt_pin(evt_pin), .evt_wdog(evt_wdog),
    .evt_ilop(evt_ilop), .evt_iladr(evt_iladr), .evt_lvd(evt_lvd),
    .brk_pulse(brk_pulse), .core_lowpwr(core_lowpwr),
    .bus_sel(bus_sel), .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // ev order: {por, pin, wdog, ilop, iladr, lvd}
  function automatic logic [7:0] model_rst(input logic [7:0] r, input logic [5:0] ev,
                                           input logic clr);
    logic [7:0] n;
    n = clr ? 8'h00 : r;
    if (ev[5]) n = 8'h80;
    else n = n | {1'b0, ev[4], ev[3], ev[2], ev[1], 1'b0, ev[0], 1'b0};
    return n;
  endfunction

  function automatic logic model_brk(input logic b, input logic [5:0] ev, input logic bp,
                                     input logic lp, input logic wz);
    if (|ev) return 1'b0;
    if (bp && lp) return 1'b1;
    if (wz) return 1'b0;
    return b;
  endfunction

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s: got 0x%02h expected 0x%02h", tag, got, exp);
    end
  endtask

  // One bus cycle: drive after the falling edge, check the read data
  // before the rising edge, advance the model, wait for the next falling edge.
  task automatic cyc(input string tag, input logic [5:0] ev, input logic bp, input logic lp,
                     input logic sel, input logic adr, input logic rd, input logic wr,
                     input logic [7:0] wd);
    logic [7:0] exp;
    logic       rdr;
    logic       wz;
    {evt_por, evt_pin, evt_wdog, evt_ilop, evt_iladr, evt_lvd} = ev;
    brk_pulse = bp; core_lowpwr = lp;
    bus_sel = sel; bus_addr = adr; bus_rd = rd; bus_wr = wr; bus_wdata = wd;
    #2;
    if (sel && rd) exp = adr ? m_rst : {6'b0, m_brk, 1'b0};
    else exp = 8'h00;
    if (sel && rd) chk(tag, bus_rdata, exp);
    rdr   = sel && rd && adr;
    wz    = sel && wr && !adr && !wd[1];
    m_rst = model_rst(m_rst, ev, rdr);
    m_brk = model_brk(m_brk, ev, bp, lp, wz);
    @(negedge clk);
  endtask

  task automatic idle();
    cyc("idle", 6'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00);
  endtask

  task automatic rd(input string tag, input logic adr);
    cyc(tag, 6'b0, 1'b0, 1'b0, 1'b1, adr, 1'b1, 1'b0, 8'h00);
  endtask

  task automatic ev(input logic [5:0] e);
    cyc("ev", e, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00);
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog: got 0x00 expected 0x01");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    checks = 0; failures = 0; done = 1'b0;
    rst_n = 1'b0;
    {evt_por, evt_pin, evt_wdog, evt_ilop, evt_iladr, evt_lvd} = 6'b0;
    brk_pulse = 1'b0; core_lowpwr = 1'b0;
    bus_sel = 1'b0; bus_addr = 1'b0; bus_rd = 1'b0; bus_wr = 1'b0; bus_wdata = 8'h00;
    m_rst = 8'h80; m_brk = 1'b0;
    #55 rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state; R11 read of break register does not clear
    rd("R1 bsr after reset", 1'b0);
    rd("R1 rsr after reset", 1'b1);
    // R4 second read shows the clear
    rd("R4 rsr cleared by read", 1'b1);
    // R2 single sources at their bit positions, sticky accumulation
    ev(6'b001000); rd("R2 watchdog bit5", 1'b1);
    ev(6'b000001); ev(6'b010000); rd("R2 lvd+pin sticky", 1'b1);
    ev(6'b000100); ev(6'b000010); rd("R2 ilop+iladr", 1'b1);
    // R3 power-on with other sources in the same cycle
    ev(6'b011111); ev(6'b111111); rd("R3 por wipes others", 1'b1);
    // R5 event during the clearing read survives
    ev(6'b000010);
    cyc("R5 read sees old value", 6'b001000, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 8'h00);
    rd("R5 event kept after read", 1'b1);
    // R6 write to reset cause register ignored
    ev(6'b000100);
    cyc("R6 wr", 6'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 8'h00);
    rd("R6 write ignored", 1'b1);
    // R8 break without low power
    cyc("R8", 6'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00);
    rd("R8 no set outside low power", 1'b0);
    // R7 break in low power
    cyc("R7", 6'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00);
    rd("R7 set in low power", 1'b0);
    rd("R11 read keeps flag", 1'b0);
    // R9 write one keeps, write zero clears, set beats clear
    cyc("R9 w1", 6'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 8'hFF);
    rd("R9 write one no effect", 1'b0);
    cyc("R9 w0", 6'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 8'hFD);
    rd("R9 write zero clears", 1'b0);
    cyc("R9 set+clr", 6'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 8'h00);
    rd("R9 set wins over clear", 1'b0);
    // R10 reset event clears, also against a set
    ev(6'b000001); rd("R10 event clears break", 1'b0);
    cyc("R10 set", 6'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00);
    cyc("R10 evt+set", 6'b010000, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00);
    rd("R10 event beats set", 1'b0);
    idle();

    // Random traffic checked against the model (R2 R3 R4 R5 R7 R8 R9 R10)
    void'($urandom(32'h5eed_0042));
    for (int i = 0; i < 4000; i++) begin
      logic [5:0] e;
      logic [2:0] op;
      e[5] = ($urandom % 64) == 0;
      for (int k = 0; k < 5; k++) e[k] = ($urandom % 12) == 0;
      op = 3'($urandom % 6);
      cyc("R4 random read", e, ($urandom % 3) == 0, ($urandom % 2) == 0,
          op != 0, 1'($urandom), op == 1 || op == 2 || op == 3,
          op == 4 || op == 5, 8'($urandom));
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule